// File: doc/BRIEF.md
# End-of-Write Status Responder

This block sits on the read path of a byte-wide nonvolatile memory whose writes are self-timed. While the write engine reports an internal programming cycle in progress, the block replaces the byte returned on each read with a status byte. The host can then find out that programming has finished by reading the device, with no interrupt line. Two methods are offered. In the first, the host re-reads the last written location until the top data bit matches what it wrote. In the second, the host reads any location until the next-to-top bit stops changing between reads.

The write engine supplies a busy level plus the address and byte of the last write, and holds them stable for the whole programming cycle. The host side supplies a read-active level, the read address and the true array data. The block drives the data byte onto the bus. A read access ends when read-active falls, which marks the rising edge of an active-low output enable. The toggle state moves on once per finished read, not once per clock. It is forced back to zero whenever the engine is idle, so every programming cycle starts from zero. While idle the block passes array data through unchanged. Bus data is combinational from the inputs and from one small piece of registered state.

Top module: `eow_responder`

## Requirements
- R1: After reset, and before any read has completed, the first read in a programming cycle returns 0 on bit 6.
- R2: While busy is low and read-active is high, the bus carries the array data unchanged.
- R3: While busy is high, a read whose address equals the last written address returns the inverse of bit 7 of the last written byte on bit 7.
- R4: While busy is high, a read of any other address returns 0 on bit 7.
- R5: While busy is high, bits 5 to 0 of every read are 0.
- R6: While busy is high, bit 6 of the bus inverts once each time a read access ends (read-active falls), and holds its value through a read access however many clocks that access lasts.
- R7: Bit 6 is cleared in every clock in which busy is low, so each new programming cycle starts its first read with bit 6 equal to 0, whatever level the previous cycle ended on.
- R8: In the first clock after busy falls, a read returns true array data on every bit, including bits 7 and 6.
- R9: While read-active is low, the bus carries all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_busy | input | 1 | Internal programming cycle in progress |
| last_addr | input | ADDR_W | Address of the last written byte |
| last_data | input | DATA_W | Value of the last written byte |
| rd_act | input | 1 | Read access in progress (high while output is enabled) |
| rd_addr | input | ADDR_W | Read address |
| array_q | input | DATA_W | True data read from the array |
| bus_q | output | DATA_W | Byte driven onto the data bus |

## Verification
The bench goes after how bit 6 behaves across read boundaries. It holds long reads of several clocks; a design that counts clocks instead of finished reads would change bit 6 in the middle of such a read. It runs back-to-back programming cycles, the first ending on an odd number of reads; a design that does not clear the toggle between cycles would begin the second cycle with bit 6 set. It reads the last written address and a different address while busy; a design that inverts bit 7 at the wrong address, or lets array bits reach the reserved field, would show up there. It also reads in the first clock after busy falls; a design that keeps status one cycle too long would return the inverted bit 7 there.

// File: rtl/eow_pkg.sv
package eow_pkg;
    // Registered state of the read-boundary detector
    typedef struct packed {
        logic rd_prev;
    } edge_st_t;

    // Registered state of the toggle tracker
    typedef struct packed {
        logic tog;
    } tog_st_t;
endpackage

// File: rtl/eow_rd_edge.sv
module eow_rd_edge
    import eow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_act,
    output logic rd_done
);
    edge_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.rd_prev = rd_act;
        rd_done      = st_q.rd_prev & ~rd_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/eow_toggle.sv
module eow_toggle
    import eow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic prog_busy,
    input  logic rd_done,
    output logic tog_bit
);
    tog_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!prog_busy)   st_d.tog = 1'b0;      // idle: start next cycle from zero
        else if (rd_done) st_d.tog = ~st_q.tog; // one step per finished read
    end

    assign tog_bit = st_q.tog;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/eow_status_mux.sv
module eow_status_mux #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              prog_busy,
    input  logic              rd_act,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [DATA_W-1:0] last_data,
    input  logic [DATA_W-1:0] array_q,
    input  logic              tog_bit,
    output logic [DATA_W-1:0] bus_q
);
    localparam int POLL_POS = DATA_W - 1;
    localparam int TOG_POS  = DATA_W - 2;

    logic [DATA_W-1:0] status;
    logic              hit;

    always_comb begin
        hit               = (rd_addr == last_addr);
        status            = '0;
        status[POLL_POS]  = hit & ~last_data[POLL_POS];
        status[TOG_POS]   = tog_bit;
        if (!rd_act)        bus_q = '0;
        else if (prog_busy) bus_q = status;
        else                bus_q = array_q;
    end
endmodule

// File: rtl/eow_responder.sv
module eow_responder #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_busy,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [DATA_W-1:0] last_data,
    input  logic              rd_act,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] array_q,
    output logic [DATA_W-1:0] bus_q
);
    logic rd_done;
    logic tog_bit;

    eow_rd_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_act  (rd_act),
        .rd_done (rd_done)
    );

    eow_toggle u_tog (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_busy (prog_busy),
        .rd_done   (rd_done),
        .tog_bit   (tog_bit)
    );

    eow_status_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .prog_busy (prog_busy),
        .rd_act    (rd_act),
        .rd_addr   (rd_addr),
        .last_addr (last_addr),
        .last_data (last_data),
        .array_q   (array_q),
        .tog_bit   (tog_bit),
        .bus_q     (bus_q)
    );
endmodule

// File: rtl/eow_responder_chk.sv
module eow_responder_chk #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prog_busy,
    input logic [ADDR_W-1:0] last_addr,
    input logic [DATA_W-1:0] last_data,
    input logic              rd_act,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] array_q,
    input logic [DATA_W-1:0] bus_q
);
    localparam int P = DATA_W - 1;
    localparam int T = DATA_W - 2;

    logic past_ok;
    logic seen_q;
    logic last_tog_q;
    logic rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok    <= 1'b0;
            seen_q     <= 1'b0;
            last_tog_q <= 1'b0;
            rd_q       <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            rd_q    <= rd_act;
            if (!prog_busy) begin
                seen_q <= 1'b0;
            end else if (rd_act) begin
                seen_q     <= 1'b1;
                last_tog_q <= bus_q[T];
            end
        end
    end

    a_r9_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act |-> bus_q == '0);
    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && !prog_busy) |-> bus_q == array_q);
    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && prog_busy) |-> bus_q[T-1:0] == '0);
    a_r3_poll_inverted: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && prog_busy && rd_addr == last_addr) |-> bus_q[P] != last_data[P]);
    a_r4_poll_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && prog_busy && rd_addr != last_addr) |-> !bus_q[P]);
    a_r6_hold_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && rd_act && rd_q && prog_busy && $past(prog_busy)) |-> $stable(bus_q[T]));
    a_r6_flip_per_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && !rd_q && prog_busy && seen_q) |-> bus_q[T] != last_tog_q);
    a_r7_fresh_cycle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && prog_busy && !seen_q) |-> !bus_q[T]);
endmodule

bind eow_responder eow_responder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_busy (prog_busy),
    .last_addr (last_addr),
    .last_data (last_data),
    .rd_act    (rd_act),
    .rd_addr   (rd_addr),
    .array_q   (array_q),
    .bus_q     (bus_q)
);

// File: tb/eow_responder_test.sv
`timescale 1ns/1ps
module eow_responder_test;
    localparam int AW = 13;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_busy = 1'b0;
    logic [AW-1:0] last_addr = '0;
    logic [DW-1:0] last_data = '0;
    logic          rd_act = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] array_q;
    logic [DW-1:0] bus_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state: finished reads in this busy cycle
    int  rd_count = 0;
    bit  rd_prev_m = 1'b0;
    bit  busy_prev_m = 1'b0;

    always #2.5 clk = ~clk;

    assign array_q = rd_addr[7:0] ^ 8'hA5;

    eow_responder #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .prog_busy(prog_busy),
        .last_addr(last_addr), .last_data(last_data),
        .rd_act(rd_act), .rd_addr(rd_addr), .array_q(array_q), .bus_q(bus_q)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            rd_count  = 0;
            rd_prev_m = 1'b0;
        end else begin
            if (!prog_busy) rd_count = 0;
            else if (rd_prev_m && !rd_act) rd_count = rd_count + 1;
            rd_prev_m = rd_act;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    // Compare against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (!rd_act) begin
                check("R9", bus_q, 0);
            end else if (!prog_busy) begin
                if (busy_prev_m) check("R8", bus_q, array_q);
                else             check("R2", bus_q, array_q);
            end else begin
                if (rd_addr == last_addr) check("R3", bus_q[7], !last_data[7]);
                else                      check("R4", bus_q[7], 0);
                check("R5", bus_q[5:0], 0);
                if (rd_count == 0) check("R7", bus_q[6], 0);
                else               check("R6", bus_q[6], rd_count % 2);
            end
        end
        busy_prev_m = prog_busy;
    end

    task automatic do_read(input logic [AW-1:0] a, input int len);
        rd_addr = a;
        rd_act  = 1'b1;
        repeat (len) @(posedge clk);
        #1 rd_act = 1'b0;
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R9", bus_q, 0);   // reset state
        @(posedge clk); #1;
        // R2: plain reads while idle
        do_read(13'h0010, 1);
        do_read(13'h1ABC, 3);
        // first programming cycle, last byte has bit 7 clear
        last_addr = 13'h0123; last_data = 8'h35; prog_busy = 1'b1;
        @(posedge clk); #1;
        rd_addr = 13'h0123; rd_act = 1'b1;
        @(negedge clk);
        check("R1", bus_q[6], 0);
        @(posedge clk); #1 rd_act = 1'b0;
        @(posedge clk); #1;
        do_read(13'h0123, 4);   // R6: held through long read
        do_read(13'h0040, 1);   // R4
        do_read(13'h0123, 2);
        do_read(13'h0123, 1);
        // odd number of finished reads: toggle is high now
        #0 prog_busy = 1'b0;
        do_read(13'h0123, 2);   // R8 in first clock after busy falls
        // second cycle, bit 7 set, must restart toggle at zero (R7)
        last_addr = 13'h1FFF; last_data = 8'hC2; prog_busy = 1'b1;
        @(posedge clk); #1;
        do_read(13'h1FFF, 1);
        do_read(13'h0000, 3);
        do_read(13'h1FFF, 5);
        // back-to-back cycles with one idle clock
        prog_busy = 1'b0;
        @(posedge clk); #1 prog_busy = 1'b1;
        do_read(13'h1FFF, 2);
        do_read(13'h1FFF, 1);
        prog_busy = 1'b0;
        do_read(13'h0777, 1);
        repeat (3) @(posedge clk);
        #1 done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule